// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is an I2C bus master driven one byte at a time from a small 32-bit register port. The host places a byte in the data register and then writes the control register with the go bit and the qualifiers for that byte: a start (or repeated start) before it, a stop after its acknowledge slot, the direction, and the acknowledge value to return when receiving. The block then clocks the byte out of or into the open-drain SCL and SDA pins and reports completion through sticky status flags that the host clears by writing ones.

A quarter-period divider paces the bus, so one SCL period is four times `QDIV` clock cycles. A bus monitor watches the pins for start and stop conditions and keeps a bus-busy flag. A unit enable idles the engine and releases both lines. A self-clearing unit-reset bit returns every register and flag to its reset value. A parameter selects the register spacing: 8-byte stride (the default) or packed 4-byte stride.

Top module: `i2cb_master`

## Requirements
- R1: After reset, the control register reads 0x0C0 (bit 7 unit enable, bit 6 SCL drive enable), status, data and own-address registers read 0, and both bus lines are released.
- R2: Register index order is bus monitor, data, control, status, own address. With `PADDED`=1 the index is placed at address bits 5:3 (stride 8) and addresses with bits 2:0 nonzero read 0. With `PADDED`=0 the index is placed at bits 4:2 (stride 4). The own-address register holds a 7-bit value.
- R3: A control write with bit 3 (go) set sends exactly one byte, most significant bit first. Control bit 0 (start) puts a start or repeated start before the byte. Afterwards status bit 0 (transmit empty) is set and go reads 0.
- R4: After a transmitted byte, status bit 2 reads 1 if the device left SDA high in the acknowledge slot and 0 if it pulled SDA low.
- R5: With control bit 4 (receive) set, the byte sampled from SDA is loaded into the data register and status bit 1 (receive full) is set. In the acknowledge slot the master drives ACK (low) when control bit 2 is 0 and NAK (released) when it is 1.
- R6: Control bit 1 (stop) issues a stop after the acknowledge slot. Without it, SCL is held low after the byte.
- R7: Status bits 0 and 1 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: Status bit 3 (bus busy) sets on any start seen on the pins and clears on any stop seen on the pins, whoever drives them.
- R9: Control writes made while a byte is in flight do not change that byte and do not launch another one.
- R10: With the unit enable (bit 7) clear, both lines are released and go writes are ignored.
- R11: With the SCL drive enable (bit 6) clear, SCL is released.
- R12: Writing control bit 8 (unit reset) returns control, data, own address and every status flag, including bus busy, to the reset values of R1.
- R13: The master changes SDA only while it drives SCL low, except while it generates a start or a stop.
- R14: The bus-monitor register reads SCL on bit 0 and SDA on bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong bit or phase counter in the engine appears within one byte time (36 quarter periods plus framing) as a byte that the bench-side device model logs with the wrong value, a missing or extra start or stop, or a go bit that never clears. A wrong latched command shows up in the acknowledge slot or in the held-low state of SCL after the byte. A stale monitor state shows up in the bus-busy bit two cycles after the pins change. The bench sweeps bytes, acknowledge choices and stop placement, and predicts each expected log entry, flag and line level from the requirement alone.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int ADDR_W = 8;
  localparam int CTRL_W = 9;

  // register indices (order is fixed)
  localparam logic [2:0] REG_MON  = 3'd0;
  localparam logic [2:0] REG_DATA = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_OWN  = 3'd4;
  localparam logic [2:0] REG_NONE = 3'd7;

  // control bit positions
  localparam int C_START = 0;
  localparam int C_STOP  = 1;
  localparam int C_NAK   = 2;
  localparam int C_GO    = 3;
  localparam int C_RX    = 4;
  localparam int C_ALIE  = 5;
  localparam int C_SCLEN = 6;
  localparam int C_EN    = 7;
  localparam int C_URST  = 8;

  localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'((1 << C_SCLEN) | (1 << C_EN));
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = ~CTRL_W'((1 << C_GO) | (1 << C_URST));

  // status bit positions
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_NAKD = 2;
  localparam int S_BUSY = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} phase_t;

  // byte address to register index; REG_NONE for gaps and misaligned addresses
  function automatic logic [2:0] reg_index(input logic [ADDR_W-1:0] a, input bit padded);
    logic [ADDR_W-1:0] w;
    if (padded) begin
      if (a[2:0] != 3'd0) return REG_NONE;
      w = a >> 3;
    end else begin
      if (a[1:0] != 2'd0) return REG_NONE;
      w = a >> 2;
    end
    return (w > ADDR_W'(4)) ? REG_NONE : w[2:0];
  endfunction

  // line pulls {scl, sda} for a framing phase in quarter q
  function automatic logic [1:0] frame_pull(input phase_t ph, input logic [1:0] q);
    if (ph == PH_START) return {q == 2'd0, q >= 2'd2};
    return {q < 2'd2, q != 2'd3};
  endfunction

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
  parameter int unsigned QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int QW = (QDIV < 2) ? 1 : $clog2(QDIV);
  localparam logic [QW-1:0] LAST = QW'(QDIV - 1);

  logic [QW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cb_busmon.sv
module i2cb_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_seen,
  output logic stop_seen,
  output logic busy
);
  logic scl_d, sda_d;

  assign start_seen = scl_d && scl_in && sda_d && !sda_in;
  assign stop_seen  = scl_d && scl_in && !sda_d && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (clr)             busy <= 1'b0;
      else if (start_seen) busy <= 1'b1;
      else if (stop_seen)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int unsigned QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       launch,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_nak,
  input  logic       cmd_rx,
  input  logic [7:0] cmd_byte,
  input  logic       sda_in,
  output logic       active,
  output logic       done,
  output logic       done_rx,
  output logic       framing,
  output logic [7:0] rx_byte,
  output logic       got_nak,
  output logic       scl_drv,
  output logic       sda_drv
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  phase_t     ph;
  logic [1:0] qtr;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       stop_q, nak_q, rx_q, hold_low, nak_seen;
  logic       tick;
  logic [1:0] fp;

  i2cb_qtick #(.QDIV(QDIV)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .tick (tick)
  );

  assign active  = (ph != PH_IDLE);
  assign framing = (ph == PH_START) || (ph == PH_STOP);
  assign done_rx = rx_q;
  assign rx_byte = sh;
  assign got_nak = nak_seen;
  assign fp      = frame_pull(ph, qtr);

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    unique case (ph)
      PH_IDLE: scl_drv = hold_low;
      PH_BITS: begin
        scl_drv = (qtr < 2'd2);
        if (bitn < ACK_SLOT) sda_drv = !rx_q && !sh[7];
        else                 sda_drv = rx_q && !nak_q;
      end
      default: {scl_drv, sda_drv} = fp;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; qtr <= '0; bitn <= '0; sh <= '0;
      stop_q <= 1'b0; nak_q <= 1'b0; rx_q <= 1'b0;
      hold_low <= 1'b0; nak_seen <= 1'b0; done <= 1'b0;
    end else if (clr) begin
      ph <= PH_IDLE; qtr <= '0; bitn <= '0; sh <= '0;
      stop_q <= 1'b0; nak_q <= 1'b0; rx_q <= 1'b0;
      hold_low <= 1'b0; nak_seen <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (launch) begin
          sh     <= cmd_byte;
          stop_q <= cmd_stop;
          nak_q  <= cmd_nak;
          rx_q   <= cmd_rx;
          qtr    <= '0;
          bitn   <= '0;
          ph     <= cmd_start ? PH_START : PH_BITS;
        end
      end else if (tick) begin
        qtr <= qtr + 1'b1;
        if (ph == PH_BITS && qtr == 2'd2) begin
          if (bitn < ACK_SLOT && rx_q)  sh <= {sh[6:0], sda_in};
          if (bitn == ACK_SLOT && !rx_q) nak_seen <= sda_in;
        end
        if (ph == PH_BITS && qtr == 2'd3 && bitn < ACK_SLOT && !rx_q)
          sh <= {sh[6:0], 1'b0};
        if (qtr == 2'd3) begin
          unique case (ph)
            PH_START: begin
              ph   <= PH_BITS;
              bitn <= '0;
            end
            PH_BITS: begin
              if (bitn != ACK_SLOT) begin
                bitn <= bitn + 1'b1;
              end else if (stop_q) begin
                ph <= PH_STOP;
              end else begin
                ph       <= PH_IDLE;
                done     <= 1'b1;
                hold_low <= 1'b1;
              end
            end
            PH_STOP: begin
              ph       <= PH_IDLE;
              done     <= 1'b1;
              hold_low <= 1'b0;
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
  import i2cb_pkg::*;
#(
  parameter int unsigned QDIV   = 4,
  parameter bit          PADDED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic [2:0]        sel;
  logic              wr_data, wr_ctrl, wr_stat, wr_own;
  logic              soft_rst, eng_clr, launch;
  logic [CTRL_W-1:0] ctrl_q;
  logic [7:0]        data_q;
  logic [6:0]        own_q;
  logic              txe, rxf, nakd;
  logic              eng_active, eng_done, eng_done_rx, eng_framing, eng_nak;
  logic [7:0]        eng_rx_byte;
  logic              scl_drv, sda_drv;
  logic              start_seen, stop_seen, bus_busy;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata[31:CTRL_W];

  assign sel     = reg_index(reg_addr, PADDED);
  assign wr_data = reg_wr && (sel == REG_DATA);
  assign wr_ctrl = reg_wr && (sel == REG_CTRL);
  assign wr_stat = reg_wr && (sel == REG_STAT);
  assign wr_own  = reg_wr && (sel == REG_OWN);

  assign soft_rst = wr_ctrl && reg_wdata[C_URST];
  assign eng_clr  = soft_rst || !ctrl_q[C_EN];
  assign launch   = wr_ctrl && reg_wdata[C_GO] && !reg_wdata[C_URST]
                    && ctrl_q[C_EN] && !eng_active;

  i2cb_engine #(.QDIV(QDIV)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (eng_clr),
    .launch   (launch),
    .cmd_start(reg_wdata[C_START]),
    .cmd_stop (reg_wdata[C_STOP]),
    .cmd_nak  (reg_wdata[C_NAK]),
    .cmd_rx   (reg_wdata[C_RX]),
    .cmd_byte (data_q),
    .sda_in   (sda_i),
    .active   (eng_active),
    .done     (eng_done),
    .done_rx  (eng_done_rx),
    .framing  (eng_framing),
    .rx_byte  (eng_rx_byte),
    .got_nak  (eng_nak),
    .scl_drv  (scl_drv),
    .sda_drv  (sda_drv)
  );

  i2cb_busmon u_busmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .scl_in    (scl_i),
    .sda_in    (sda_i),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .busy      (bus_busy)
  );

  assign scl_oe = ctrl_q[C_SCLEN] && scl_drv;
  assign sda_oe = sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET; data_q <= '0; own_q <= '0;
      txe <= 1'b0; rxf <= 1'b0; nakd <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_RESET; data_q <= '0; own_q <= '0;
      txe <= 1'b0; rxf <= 1'b0; nakd <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (wr_own)  own_q  <= reg_wdata[6:0];
      if (eng_done && eng_done_rx) data_q <= eng_rx_byte;
      else if (wr_data)            data_q <= reg_wdata[7:0];

      if (eng_done && !eng_done_rx)      txe <= 1'b1;
      else if (wr_stat && reg_wdata[S_TXE]) txe <= 1'b0;
      if (eng_done && eng_done_rx)       rxf <= 1'b1;
      else if (wr_stat && reg_wdata[S_RXF]) rxf <= 1'b0;
      if (eng_done && !eng_done_rx)      nakd <= eng_nak;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_MON:  reg_rdata[1:0] = {sda_i, scl_i};
      REG_DATA: reg_rdata[7:0] = data_q;
      REG_CTRL: begin
        reg_rdata[CTRL_W-1:0] = ctrl_q;
        reg_rdata[C_GO]       = eng_active;
      end
      REG_STAT: begin
        reg_rdata[S_TXE]  = txe;
        reg_rdata[S_RXF]  = rxf;
        reg_rdata[S_NAKD] = nakd;
        reg_rdata[S_BUSY] = bus_busy;
      end
      REG_OWN:  reg_rdata[6:0] = own_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic eng_clr,
  input logic en,
  input logic scl_drv,
  input logic scl_oe,
  input logic sda_oe,
  input logic framing,
  input logic done,
  input logic done_rx,
  input logic txe,
  input logic rxf,
  input logic start_seen,
  input logic stop_seen,
  input logic busy
);
  AST_SDA_ONLY_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_drv && !$past(scl_drv) && !$past(eng_clr)) |-> framing); // R13
  AST_DISABLED_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe)); // R10
  AST_TX_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_rx && !soft_rst) |=> txe); // R3
  AST_RX_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_rx && !soft_rst) |=> rxf); // R5
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !soft_rst) |=> busy); // R8
  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !busy); // R8
  AST_UNIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!txe && !rxf && !busy)); // R12
endmodule

bind i2cb_master i2cb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .eng_clr   (eng_clr),
  .en        (ctrl_q[i2cb_pkg::C_EN]),
  .scl_drv   (scl_drv),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .framing   (eng_framing),
  .done      (eng_done),
  .done_rx   (eng_done_rx),
  .txe       (txe),
  .rxf       (rxf),
  .start_seen(start_seen),
  .stop_seen (stop_seen),
  .busy      (bus_busy)
);

// File: tb/i2cb_master_tb_top.sv
module i2cb_master_tb_top;
  localparam logic [7:0] A_MON = 8'h00, A_DATA = 8'h08, A_CTRL = 8'h10,
                         A_STAT = 8'h18, A_OWN = 8'h20;
  localparam logic [31:0] B_START = 32'h1, B_STOP = 32'h2, B_NAK = 32'h4,
                          B_GO = 32'h8, B_RX = 32'h10, B_SCLEN = 32'h40,
                          B_EN = 32'h80, B_URST = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0, reg_wr2 = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, reg_rdata2;
  logic        scl_oe, sda_oe, scl_oe2, sda_oe2;
  logic        bsda = 1'b0, bpull = 1'b0;
  wire         scl_line = ~scl_oe;
  wire         sda_line = ~(sda_oe | bsda | bpull);

  int vectors = 0, miscompares = 0;

  i2cb_master #(.QDIV(4), .PADDED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  i2cb_master #(.QDIV(4), .PADDED(1'b0)) dut_flat_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr2), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata2),
    .scl_i(1'b1), .sda_i(1'b1), .scl_oe(scl_oe2), .sda_oe(sda_oe2));

  // behavioural device on the bus
  logic       ps = 1'b1, pd = 1'b1, saw_rise = 1'b0;
  int         scnt = 0, starts = 0, stops = 0, nbytes = 0;
  logic [7:0] ssh = '0, log_byte = '0, txb = '0;
  logic       mack = 1'b0, slave_ack = 1'b1, slave_tx = 1'b0;

  always @(negedge clk) begin
    if (ps && scl_line && pd && !sda_line) begin
      starts++; scnt = 0; saw_rise = 0; mack = 0;
    end else if (ps && scl_line && !pd && sda_line) begin
      stops++;
    end else if (!ps && scl_line) begin
      saw_rise = 1;
      if (scnt < 8) ssh = {ssh[6:0], sda_line};
      else mack = sda_line;
    end else if (ps && !scl_line && saw_rise) begin
      saw_rise = 0;
      if (scnt == 8) begin scnt = 0; log_byte = ssh; nbytes++; end
      else scnt++;
    end
    if (!scl_line) begin
      if (scnt == 8) bsda = !slave_tx && slave_ack;
      else if (slave_tx && !(scnt == 0 && mack)) bsda = ~txb[7-scnt];
      else bsda = 1'b0;
    end
    ps = scl_line; pd = sda_line;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr2(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr2 = 1'b1;
    @(negedge clk); reg_wr2 = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd2(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata2;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    do begin rd(A_CTRL, v); n++; end while (v[3] && n < 4000);
    check({req, " go self-clears"}, {31'b0, v[3]}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input logic [31:0] flags, input string req);
    wr(A_DATA, {24'b0, b});
    wr(A_CTRL, B_EN | B_SCLEN | B_GO | flags);
    wait_idle(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int se, pe, ne;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R14: reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0C0);
    rd(A_STAT, v); check("R1 stat", v, 32'h0);
    rd(A_DATA, v); check("R1 data", v, 32'h0);
    rd(A_OWN, v);  check("R1 own", v, 32'h0);
    rd(A_MON, v);  check("R14 monitor idle", v, 32'h3);

    // R2: register placement, both strides
    wr(A_OWN, 32'h55);   rd(A_OWN, v);  check("R2 own padded", v, 32'h55);
    rd(8'h04, v);                         check("R2 pad word", v, 32'h0);
    wr2(8'h10, 32'h2A);  rd2(8'h10, v);  check("R2 own flat", v, 32'h2A);
    wr2(8'h04, 32'h77);  rd2(8'h04, v);  check("R2 data flat", v, 32'h77);

    // R3/R4/R6/R7/R8: transmit sweep
    se = 0; pe = 0; ne = 0;
    slave_tx = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      logic ack, stp;
      b = 8'h5A ^ 8'(i * 37);
      ack = (i % 3) != 1;
      stp = (i % 2) == 1;
      slave_ack = ack;
      xfer(b, B_START | (stp ? B_STOP : 32'h0), "R3");
      se++; ne++; if (stp) pe++;
      check("R3 byte on bus", {24'b0, log_byte}, {24'b0, b});
      check("R3 start count", starts, se);
      check("R6 stop count", stops, pe);
      check("R3 byte count", nbytes, ne);
      rd(A_STAT, v);
      check("R3 tx empty", {31'b0, v[0]}, 32'd1);
      check("R4 nak status", {31'b0, v[2]}, {31'b0, !ack});
      check("R8 busy", {31'b0, v[3]}, {31'b0, !stp});
      check("R6 scl level", {31'b0, scl_line}, {31'b0, stp});
      wr(A_STAT, 32'h0); rd(A_STAT, v);
      check("R7 write 0 keeps", {31'b0, v[0]}, 32'd1);
      wr(A_STAT, 32'h1); rd(A_STAT, v);
      check("R7 write 1 clears", {31'b0, v[0]}, 32'd0);
    end

    // R5: receive sweep after an acknowledged address byte
    slave_ack = 1'b1;
    xfer(8'hA1, B_START, "R5 addr");
    se++; ne++;
    slave_tx = 1'b1;
    for (int j = 0; j < 4; j++) begin
      logic last;
      last = (j == 3);
      txb = 8'h3C ^ 8'(j * 83);
      xfer(8'h00, B_RX | (last ? (B_NAK | B_STOP) : 32'h0), "R5");
      ne++; if (last) pe++;
      rd(A_DATA, v); check("R5 received byte", v, {24'b0, txb});
      rd(A_STAT, v); check("R5 rx full", {31'b0, v[1]}, 32'd1);
      check("R5 master ack value", {31'b0, mack}, {31'b0, last});
      wr(A_STAT, 32'h2); rd(A_STAT, v);
      check("R7 rx full cleared", {31'b0, v[1]}, 32'd0);
    end
    slave_tx = 1'b0;
    check("R6 stop after rx", stops, pe);
    check("R5 byte count", nbytes, ne);
    rd(A_STAT, v); check("R8 idle after stop", {31'b0, v[3]}, 32'd0);

    // R9: control writes during a byte
    slave_ack = 1'b1;
    wr(A_DATA, 32'hC3);
    wr(A_CTRL, B_EN | B_SCLEN | B_GO | B_START);
    repeat (40) @(negedge clk);
    wr(A_CTRL, B_EN | B_SCLEN | B_GO | B_STOP | B_RX);
    wr(A_DATA, 32'h00);
    wait_idle("R9");
    se++; ne++;
    check("R9 byte unchanged", {24'b0, log_byte}, 32'hC3);
    check("R9 no stop added", stops, pe);
    check("R6 scl held low", {31'b0, scl_line}, 32'd0);
    repeat (400) @(negedge clk);
    check("R9 no second byte", nbytes, ne);
    rd(A_CTRL, v); check("R9 ctrl stored, go low", v, 32'h0D2);

    // R11: SCL drive enable
    wr(A_CTRL, B_EN); repeat (2) @(negedge clk);
    rd(A_MON, v); check("R11 scl released", {31'b0, v[0]}, 32'd1);
    wr(A_CTRL, B_EN | B_SCLEN); repeat (2) @(negedge clk);
    check("R11 scl held again", {31'b0, scl_line}, 32'd0);

    // R10: unit disabled
    wr(A_CTRL, B_SCLEN); repeat (2) @(negedge clk);
    check("R10 lines released", {30'b0, scl_line, sda_line}, 32'h3);
    wr(A_CTRL, B_SCLEN | B_GO | B_START);
    repeat (400) @(negedge clk);
    check("R10 go ignored", nbytes, ne);
    rd(A_CTRL, v); check("R10 go reads 0", {31'b0, v[3]}, 32'd0);
    check("R10 scl still released", {31'b0, scl_line}, 32'd1);
    wr(A_CTRL, B_EN | B_SCLEN); repeat (2) @(negedge clk);
    check("R10 no hold after enable", {31'b0, scl_line}, 32'd1);

    // R8: start and stop made by another device
    rd(A_STAT, v); check("R8 busy before", {31'b0, v[3]}, 32'd1);
    @(negedge clk); bpull = 1'b1; repeat (3) @(negedge clk);
    @(negedge clk); bpull = 1'b0; repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R8 external stop clears", {31'b0, v[3]}, 32'd0);
    @(negedge clk); bpull = 1'b1; repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R8 external start sets", {31'b0, v[3]}, 32'd1);

    // R12: unit reset while flags set and bus busy
    wr(A_DATA, 32'h99);
    rd(A_STAT, v); check("R12 flag set before", {31'b0, v[0]}, 32'd1);
    wr(A_CTRL, B_EN | B_URST);
    rd(A_CTRL, v); check("R12 ctrl default", v, 32'h0C0);
    rd(A_STAT, v); check("R12 status cleared", v, 32'h0);
    rd(A_OWN, v);  check("R12 own cleared", v, 32'h0);
    rd(A_DATA, v); check("R12 data cleared", v, 32'h0);
    @(negedge clk); bpull = 1'b0; repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule